// File: doc/BRIEF.md
# Pixel-Doubling Video Scan-Out with Character Overlay

This block turns the coordinate stream of a separate 640x480 timing generator into 4-bit-per-channel colour. Its image comes from two on-chip memories that sit outside the block. The first is a 320x240 frame store of 16-bit 5/6/5 RGB words. Each stored pixel covers a 2x2 square of the screen. The second is an 8K x 8 text store that holds one code per 8x8 screen cell. A non-zero code whose glyph bit is set at the current position paints the pixel white over the frame-store image.

On every clock the block takes a screen coordinate and a display-enable. It registers the read addresses for both memories and waits for the synchronous read data. It then evaluates the glyph bit, picks the colour source and truncates it to 4 bits. The display-enable and the position-within-cell bits travel through a matching delay line. Colour and blanking therefore leave the block a fixed three clocks after their coordinate, and the sync outputs of the timing generator only need the same three-clock delay. Both memories return data one clock after they see an address.

Top module: `vga_pixdbl_overlay`

## Requirements
- R1: While `rst` is high, at every rising edge all colour outputs and both address outputs are cleared to zero, whatever the coordinate inputs carry.
- R2: The frame-store address equals (y/2)*320 + (x/2), using integer division. It appears on `fb_addr` one clock after `x_in`/`y_in` are sampled, so all four screen pixels of a 2x2 square read the same word. Screen (0,0) is the top-left corner and maps to word 0.
- R3: The text-store address equals (y/8)*80 + (x/8), using integer division. It appears on `txt_addr` one clock after the coordinate is sampled.
- R4: The colour for a coordinate sampled at rising edge N appears on the colour outputs right after edge N+3. This holds when both memories return read data one clock after the address is presented.
- R5: When the pixel-buffer word is shown, red = word[15:12], green = word[10:7] and blue = word[4:1].
- R6: If the text code is non-zero and its bit number ((x mod 8) + (y mod 8)) mod 8 is 1, the output is white: all three channels are 4'hF.
- R7: If the text code is zero, or its selected bit is 0, the frame-store colour of R5 is shown.
- R8: If display-enable was low for the coordinate, all three channels are zero, even when R6 would otherwise produce white. Blanking is delayed by the same latency as the colour.
- R9: The bottom-right coordinate (639,479) reads frame word 76799 and text cell 4799. Addresses for in-range coordinates never exceed these values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| x_in | input | 10 | Screen column from the timing generator |
| y_in | input | 9 | Screen row from the timing generator |
| de_in | input | 1 | Display-enable for this coordinate |
| fb_addr | output | 17 | Frame-store read address |
| fb_data | input | 16 | Frame-store read data, valid one clock after the address |
| txt_addr | output | 13 | Text-store read address |
| txt_code | input | 8 | Text-store read data, valid one clock after the address |
| red | output | 4 | Red channel |
| green | output | 4 | Green channel |
| blue | output | 4 | Blue channel |

## Verification
Overlay selection and blanking can both apply to the same output cycle: a lit glyph bit in a cell whose coordinate arrives with display-enable low. The bench sets every text cell to code 8'h01, so bit 0 lights at each position where (x mod 8 + y mod 8) mod 8 is 0. It then drives such positions once with enable high, expecting white, and once with enable low, expecting black. The enable input also toggles inside a run of overlay positions, so a blanking delay that differs from the colour delay by even one clock produces a wrong colour at a known cycle.

// File: rtl/vga_pixdbl_overlay.sv
`timescale 1ns/1ps
module vga_pixdbl_overlay #(
  parameter int SCR_W    = 640,
  parameter int SCR_H    = 480,
  parameter int SCALE_SH = 1,
  parameter int CELL_SH  = 3,
  parameter int TXT_DEPTH = 8192,
  parameter int WORD_W   = 16,
  parameter int CODE_W   = 8,
  parameter int CH_W     = 4
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [$clog2(SCR_W)-1:0]               x_in,
  input  logic [$clog2(SCR_H)-1:0]               y_in,
  input  logic                                   de_in,
  output logic [$clog2((SCR_W>>SCALE_SH)*(SCR_H>>SCALE_SH))-1:0] fb_addr,
  input  logic [WORD_W-1:0]                      fb_data,
  output logic [$clog2(TXT_DEPTH)-1:0]           txt_addr,
  input  logic [CODE_W-1:0]                      txt_code,
  output logic [CH_W-1:0]                        red,
  output logic [CH_W-1:0]                        green,
  output logic [CH_W-1:0]                        blue
);
  localparam int XW       = $clog2(SCR_W);
  localparam int YW       = $clog2(SCR_H);
  localparam int BUF_W    = SCR_W >> SCALE_SH;
  localparam int BUF_H    = SCR_H >> SCALE_SH;
  localparam int FB_DEPTH = BUF_W * BUF_H;
  localparam int FB_AW    = $clog2(FB_DEPTH);
  localparam int COLS     = SCR_W >> CELL_SH;
  localparam int ROWS     = SCR_H >> CELL_SH;
  localparam int CELLS    = COLS * ROWS;
  localparam int TXT_AW   = $clog2(TXT_DEPTH);

  logic [XW-1:0]      bx, cx;
  logic [YW-1:0]      by, cy;
  logic [CELL_SH-1:0] sub_now;
  logic [CELL_SH-1:0] sub_p0, sub_p1;
  logic               de_p0, de_p1, de_p2;
  logic               glyph_on;
  logic [WORD_W-1:0]  word_q;

  assign bx = x_in >> SCALE_SH;
  assign by = y_in >> SCALE_SH;
  assign cx = x_in >> CELL_SH;
  assign cy = y_in >> CELL_SH;
  assign sub_now = x_in[CELL_SH-1:0] + y_in[CELL_SH-1:0];

  // stage 0: addresses out, side info into the delay line
  always_ff @(posedge clk) begin
    if (rst) begin
      fb_addr  <= '0;
      txt_addr <= '0;
      de_p0    <= 1'b0;
      sub_p0   <= '0;
    end else begin
      fb_addr  <= FB_AW'(by * BUF_W + bx);
      txt_addr <= TXT_AW'(cy * COLS + cx);
      de_p0    <= de_in;
      sub_p0   <= sub_now;
    end
  end

  // stage 1: memories answer; side info waits one clock
  always_ff @(posedge clk) begin
    if (rst) begin
      de_p1  <= 1'b0;
      sub_p1 <= '0;
    end else begin
      de_p1  <= de_p0;
      sub_p1 <= sub_p0;
    end
  end

  // stage 2: glyph lookup and pixel capture
  always_ff @(posedge clk) begin
    if (rst) begin
      glyph_on <= 1'b0;
      word_q   <= '0;
      de_p2    <= 1'b0;
    end else begin
      glyph_on <= (txt_code != '0) && txt_code[sub_p1];
      word_q   <= fb_data;
      de_p2    <= de_p1;
    end
  end

  // stage 3: source select, truncation, blanking
  always_ff @(posedge clk) begin
    if (rst || !de_p2) begin
      red   <= '0;
      green <= '0;
      blue  <= '0;
    end else if (glyph_on) begin
      red   <= '1;
      green <= '1;
      blue  <= '1;
    end else begin
      red   <= word_q[15 -: CH_W];
      green <= word_q[10 -: CH_W];
      blue  <= word_q[4  -: CH_W];
    end
  end

  // cycles since reset, so history checks never reach into reset
  logic [2:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 3'd4) warm <= warm + 3'd1;
  end

  p_blank_r8: assert property (@(posedge clk) disable iff (rst)
    (warm == 3'd4 && !$past(de_in, 4)) |-> (red == '0 && green == '0 && blue == '0));

  p_white_r6: assert property (@(posedge clk) disable iff (rst)
    (warm == 3'd4 && $past(de_in, 4) &&
     ((($past(txt_code, 2)) >> CELL_SH'($past(x_in[CELL_SH-1:0], 4) + $past(y_in[CELL_SH-1:0], 4))) & CODE_W'(1)) != '0)
    |-> (red == '1 && green == '1 && blue == '1));

  p_pixel_r7: assert property (@(posedge clk) disable iff (rst)
    (warm == 3'd4 && $past(de_in, 4) && $past(txt_code, 2) == '0)
    |-> (red == $past(fb_data[15:12], 2) && green == $past(fb_data[10:7], 2) && blue == $past(fb_data[4:1], 2)));

  p_pair_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (warm == 3'd4 && ($past(x_in) >> SCALE_SH) == (x_in >> SCALE_SH) &&
     ($past(y_in) >> SCALE_SH) == (y_in >> SCALE_SH)) |=> $stable(fb_addr));

  p_addr_range_r9: assert property (@(posedge clk) disable iff (rst)
    (warm == 3'd4 && $past(x_in) < XW'(SCR_W) && $past(y_in) < YW'(SCR_H))
    |-> (fb_addr < FB_AW'(FB_DEPTH) && txt_addr < TXT_AW'(CELLS)));
endmodule

// File: tb/vga_pixdbl_overlay_tb_top.sv
`timescale 1ns/1ps
module vga_pixdbl_overlay_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  x_in = '0;
  logic [8:0]  y_in = '0;
  logic        de_in = 1'b0;
  logic [16:0] fb_addr;
  logic [15:0] fb_data = '0;
  logic [12:0] txt_addr;
  logic [7:0]  txt_code = '0;
  logic [3:0]  red, green, blue;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int txt_mode = 0;
  bit done = 0;

  int          cdue_q[$];
  logic [11:0] crgb_q[$];
  string       ctag_q[$];
  int          adue_q[$];
  int          afb_q[$];
  int          atx_q[$];
  string       atag_q[$];

  always #10 clk = ~clk;

  vga_pixdbl_overlay dut_i (
    .clk(clk), .rst(rst), .x_in(x_in), .y_in(y_in), .de_in(de_in),
    .fb_addr(fb_addr), .fb_data(fb_data), .txt_addr(txt_addr), .txt_code(txt_code),
    .red(red), .green(green), .blue(blue));

  function automatic logic [15:0] word_of(int a);
    return 16'(a * 40503 + (a >>> 5));
  endfunction

  function automatic logic [7:0] code_of(int a);
    if (txt_mode == 1) return (a % 3 == 1) ? 8'(a * 37 + 11) : 8'h00;
    if (txt_mode == 2) return 8'h01;
    return 8'h00;
  endfunction

  // memory models: one clock of read latency
  always @(posedge clk) begin
    cyc      <= cyc + 1;
    fb_data  <= word_of(int'(fb_addr));
    txt_code <= code_of(int'(txt_addr));
  end

  function automatic logic [11:0] expect_rgb(int x, int y, bit de, output string tag);
    logic [15:0] w;
    logic [7:0]  c;
    int k;
    w = word_of((y / 2) * 320 + x / 2);
    c = code_of((y / 8) * 80 + x / 8);
    k = ((x % 8) + (y % 8)) % 8;
    if (!de) begin tag = "R4 R8 blank"; return 12'h000; end
    if (c != 0 && c[k]) begin tag = "R4 R6 glyph"; return 12'hFFF; end
    tag = (c != 0) ? "R4 R7 glyph bit clear" : "R4 R5 R7 pixel";
    return {w[15:12], w[10:7], w[4:1]};
  endfunction

  task automatic drive(int x, int y, bit de);
    string t;
    logic [11:0] e;
    @(negedge clk);
    x_in  = 10'(x);
    y_in  = 9'(y);
    de_in = de;
    e = expect_rgb(x, y, de, t);
    cdue_q.push_back(cyc + 4);
    crgb_q.push_back(e);
    ctag_q.push_back(t);
    adue_q.push_back(cyc + 1);
    afb_q.push_back((y / 2) * 320 + x / 2);
    atx_q.push_back((y / 8) * 80 + x / 8);
    atag_q.push_back((x == 639 && y == 479) ? "R2 R3 R9 corner" : "R2 R3");
  endtask

  task automatic drain();
    repeat (6) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (cdue_q.size() > 0 && cdue_q[0] == cyc) begin
      checks++;
      if ({red, green, blue} !== crgb_q[0]) begin
        fails++;
        $display("FAIL %s: actual=%h expected=%h", ctag_q[0], {red, green, blue}, crgb_q[0]);
      end
      void'(cdue_q.pop_front());
      void'(crgb_q.pop_front());
      void'(ctag_q.pop_front());
    end
    if (adue_q.size() > 0 && adue_q[0] == cyc) begin
      checks++;
      if (int'(fb_addr) != afb_q[0] || int'(txt_addr) != atx_q[0]) begin
        fails++;
        $display("FAIL %s: actual=%0d/%0d expected=%0d/%0d", atag_q[0],
                 fb_addr, txt_addr, afb_q[0], atx_q[0]);
      end
      void'(adue_q.pop_front());
      void'(afb_q.pop_front());
      void'(atx_q.pop_front());
      void'(atag_q.pop_front());
    end
  end

  initial begin
    x_in = 10'd300; y_in = 9'd200; de_in = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({red, green, blue, fb_addr, txt_addr} !== '0) begin
      fails++;
      $display("FAIL R1 reset: actual=%h/%0d/%0d expected=000/0/0", {red, green, blue}, fb_addr, txt_addr);
    end
    @(negedge clk);
    rst = 1'b0; de_in = 1'b0;
    drain();

    txt_mode = 0;
    for (int y = 0; y < 2; y++)
      for (int x = 0; x < 640; x++) drive(x, y, 1'b1);
    for (int i = 0; i < 16; i++) drive(0, 0, 1'b0);
    drain();

    txt_mode = 1;
    for (int y = 100; y < 116; y++)
      for (int x = 200; x < 264; x++) drive(x, y, (x % 3) != 0);
    drain();

    txt_mode = 2;
    for (int y = 0; y < 8; y++)
      for (int x = 0; x < 16; x++) drive(x, y, 1'b1);
    drive(0, 0, 1'b0);
    drive(7, 1, 1'b0);
    drive(0, 0, 1'b1);
    drive(8, 8, 1'b0);
    drive(8, 8, 1'b1);
    drain();

    txt_mode = 1;
    drive(639, 479, 1'b1);
    drive(638, 478, 1'b1);
    drive(0, 0, 1'b1);
    drive(1, 1, 1'b1);
    drive(639, 479, 1'b0);
    drain();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R4 watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule